// File: doc/BRIEF.md
# Way-Predicting Two-Way Read Cache

This block is a small two-way set-associative read cache that shortens the common hit path by guessing the way before the tag check finishes. Each set holds one predictor bit naming the way expected to hit next. When a lookup starts, the data multiplexer is already steered by that guess. Only the guessed way's tag is compared, while its data word is read at the same time. A correct guess returns the word one cycle after the request is accepted. A wrong guess costs one more cycle, in which the other way is compared.

If neither way holds the line, the cache asks a refill port for the whole line. The refill returns four words, one per valid beat, in ascending word order. The line is written into the way the predictor did not name, and the predictor is then pointed at it. The requested word is returned once the line is complete. Any response that did not come from the guessed way in the first cycle carries a slow flag. A new request is taken while the cache is idle, and also in the cycle that delivers a first-cycle hit, so fast hits can stream back to back. Addresses are word addresses: word offset in bits [1:0], set index in bits [5:2], tag in the bits above.

Top module: `wp_cache`

## Requirements
- R1: After reset every line is invalid and every set's predictor names way 0, so the first access to any set is a miss.
- R2: A hit in the predicted way drives rsp_valid in the cycle after the request is accepted, with rsp_slow low.
- R3: A hit in the non-predicted way drives rsp_valid two cycles after acceptance with rsp_slow high, issues no refill request, and is not followed by a response in the next cycle.
- R4: After a hit in the non-predicted way, that set's predictor names the way that hit, so a repeat access to the same line is a first-cycle hit.
- R5: On a miss in both ways, mem_req_valid rises with mem_req_line equal to the request address without its two offset bits, and stays high with a stable line until mem_req_ready is seen; no response is given while it is high.
- R6: A refill replaces the way not named by the set's predictor, and afterwards the predictor names the refilled way.
- R7: Refill data arrives as four beats on mem_rsp_valid for word offsets 0, 1, 2, 3 in that order, gaps allowed; the cycle after the last beat, the requested word is returned with rsp_slow high.
- R8: req_ready is high when idle and in a cycle that delivers a first-cycle hit, and low during a second-cycle check, a refill, and the refill response.
- R9: rsp_data is the word at the requested offset of the line as supplied by the refill port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache can take a request this cycle |
| req_addr | input | ADDR_W | Word address of the read |
| rsp_valid | output | 1 | Read data valid this cycle |
| rsp_data | output | DATA_W | Read data |
| rsp_slow | output | 1 | Response did not come from a first-cycle predicted hit |
| mem_req_valid | output | 1 | Line refill request |
| mem_req_ready | input | 1 | Refill port accepts the request |
| mem_req_line | output | ADDR_W-2 | Line address of the refill |
| mem_rsp_valid | input | 1 | Refill data beat valid |
| mem_rsp_data | input | DATA_W | Refill data beat |

## Verification
A corrupted predictor bit does not give wrong data; it shows only as a response one cycle late with rsp_slow set, on the next access to that set, so the bench compares the exact response cycle of every request against a behavioural model of tags, valid bits and predictors. A wrong victim choice stays hidden until a later access to the evicted line, which then misses or comes back slow instead of fast; the sequences revisit lines in the same set to expose it. Wrong beat placement during refill shows as bad data on a later hit to another offset of the same line, so every offset of filled lines is read back.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int WAYS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LK1,
    ST_LK2,
    ST_FREQ,
    ST_FDATA,
    ST_RESP
  } wpc_state_e;
endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store
  import wpc_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int TAG_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SETS)-1:0]  rd_idx,
  input  logic                     rd_way,
  output logic                     rd_valid,
  output logic [TAG_W-1:0]         rd_tag,
  input  logic                     wr_en,
  input  logic [$clog2(SETS)-1:0]  wr_idx,
  input  logic                     wr_way,
  input  logic [TAG_W-1:0]         wr_tag
);
  logic [WAYS-1:0]  vld_w;
  logic [TAG_W-1:0] tag_w [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic WAY_ID = 1'(w);
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  vld_d;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             we;

    assign we = wr_en && (wr_way == WAY_ID);

    always_comb begin
      vld_d = vld_q;
      if (we) vld_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  vld_q <= '0;
      else if (we) vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (we) tag_q[wr_idx] <= wr_tag;
    end

    assign vld_w[w] = vld_q[rd_idx];
    assign tag_w[w] = tag_q[rd_idx];
  end

  assign rd_valid = vld_w[rd_way];
  assign rd_tag   = tag_w[rd_way];
endmodule

// File: rtl/wpc_data_store.sv
module wpc_data_store
  import wpc_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32
) (
  input  logic                                   clk,
  input  logic [$clog2(SETS)+$clog2(WORDS)-1:0]  rd_addr,
  input  logic                                   rd_way,
  output logic [DATA_W-1:0]                      rd_data,
  input  logic                                   wr_en,
  input  logic [$clog2(SETS)+$clog2(WORDS)-1:0]  wr_addr,
  input  logic                                   wr_way,
  input  logic [DATA_W-1:0]                      wr_data
);
  localparam int DEPTH = SETS * WORDS;

  logic [DATA_W-1:0] data_w [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic WAY_ID = 1'(w);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == WAY_ID)) mem_q[wr_addr] <= wr_data;
    end

    assign data_w[w] = mem_q[rd_addr];
  end

  assign rd_data = data_w[rd_way];
endmodule

// File: rtl/wpc_pred_table.sv
module wpc_pred_table #(
  parameter int SETS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SETS)-1:0]  rd_idx,
  output logic                     rd_way,
  input  logic                     wr_en,
  input  logic [$clog2(SETS)-1:0]  wr_idx,
  input  logic                     wr_way
);
  logic [SETS-1:0] pred_q;
  logic [SETS-1:0] pred_d;

  always_comb begin
    pred_d = pred_q;
    if (wr_en) pred_d[wr_idx] = wr_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pred_q <= '0;
    else if (wr_en) pred_q <= pred_d;
  end

  assign rd_way = pred_q[rd_idx];
endmodule

// File: rtl/wp_cache.sv
module wp_cache
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SETS   = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_data,
  output logic                        rsp_slow,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic [ADDR_W-$clog2(WORDS)-1:0] mem_req_line,
  input  logic                        mem_rsp_valid,
  input  logic [DATA_W-1:0]           mem_rsp_data
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

  // reset synchronizer: asserts at once, releases on the clock
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic rst_i_n;
  assign rst_i_n = rst_s2_q;

  wpc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [OFF_W-1:0]  beat_q, beat_d;
  logic              addr_en, beat_en;

  logic [OFF_W-1:0]  off;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  assign off = addr_q[OFF_W-1:0];
  assign idx = addr_q[OFF_W +: IDX_W];
  assign tag = addr_q[ADDR_W-1 -: TAG_W];

  logic             pred_way, sel_way, victim;
  logic             way_valid;
  logic [TAG_W-1:0] way_tag;
  logic             hit;
  logic             accept;
  logic             fill_beat, fill_last;
  logic             pred_we;

  // lookup steering: guessed way first, other way in the second cycle
  assign sel_way   = (state_q == ST_LK2) ? ~pred_way : pred_way;
  assign victim    = ~pred_way;
  assign hit       = way_valid && (way_tag == tag);
  assign fill_beat = (state_q == ST_FDATA) && mem_rsp_valid;
  assign fill_last = fill_beat && (beat_q == LAST_BEAT);
  assign pred_we   = ((state_q == ST_LK2) && hit) || fill_last;

  assign req_ready     = (state_q == ST_IDLE) || ((state_q == ST_LK1) && hit);
  assign accept        = req_valid && req_ready;
  assign rsp_valid     = (((state_q == ST_LK1) || (state_q == ST_LK2)) && hit)
                         || (state_q == ST_RESP);
  assign rsp_slow      = rsp_valid && (state_q != ST_LK1);
  assign mem_req_valid = (state_q == ST_FREQ);
  assign mem_req_line  = addr_q[ADDR_W-1 -: LINE_W];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_LK1;
      ST_LK1:   if (hit) state_d = accept ? ST_LK1 : ST_IDLE;
                else     state_d = ST_LK2;
      ST_LK2:   state_d = hit ? ST_IDLE : ST_FREQ;
      ST_FREQ:  if (mem_req_ready) state_d = ST_FDATA;
      ST_FDATA: if (fill_last) state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    addr_en = accept;
    addr_d  = req_addr;
    beat_en = fill_beat || (state_q == ST_FREQ);
    beat_d  = (state_q == ST_FREQ) ? '0 : beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  wpc_pred_table #(.SETS(SETS)) u_pred (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .rd_idx (idx),
    .rd_way (pred_way),
    .wr_en  (pred_we),
    .wr_idx (idx),
    .wr_way (victim)
  );

  wpc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .rd_idx   (idx),
    .rd_way   (sel_way),
    .rd_valid (way_valid),
    .rd_tag   (way_tag),
    .wr_en    (fill_last),
    .wr_idx   (idx),
    .wr_way   (victim),
    .wr_tag   (tag)
  );

  wpc_data_store #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rd_addr ({idx, off}),
    .rd_way  (sel_way),
    .rd_data (rsp_data),
    .wr_en   (fill_beat),
    .wr_addr ({idx, beat_q}),
    .wr_way  (victim),
    .wr_data (mem_rsp_data)
  );
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int LINE_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_slow,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [LINE_W-1:0] mem_req_line
);
  // R2: a first-cycle response always follows an accepted request
  p_fast_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_slow) |-> $past(req_valid && req_ready));

  // R8: no request is taken while slow work or a refill is under way
  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rsp_valid && rsp_slow) || mem_req_valid) |-> !req_ready);

  // R5: refill request held with a stable line until taken
  p_line_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_line)));

  // R5: no response while the refill request is pending
  p_no_rsp_in_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rsp_valid);

  // R3: a slow response returns to idle, so none follows directly
  p_slow_then_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_slow) |=> !rsp_valid);
endmodule

bind wp_cache wpc_checker #(.LINE_W(LINE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_slow      (rsp_slow),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_line  (mem_req_line)
);

// File: tb/wp_cache_tb.sv
module wp_cache_tb;
  localparam int ADDR_W = 16;
  localparam int SETS   = 16;
  localparam int WORDS  = 4;
  localparam int DATA_W = 32;
  localparam int LINE_W = ADDR_W - 2;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_slow;
  logic              mem_req_valid;
  logic              mem_req_ready;
  logic [LINE_W-1:0] mem_req_line;
  logic              mem_rsp_valid;
  logic [DATA_W-1:0] mem_rsp_data;

  int checks = 0;
  int errors = 0;
  int mem_reqs = 0;
  logic [LINE_W-1:0] exp_line;

  // behavioural model state
  int mtag  [SETS][2];
  bit mval  [SETS][2];
  bit mpred [SETS];

  wp_cache #(.ADDR_W(ADDR_W), .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_slow(rsp_slow),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_line(mem_req_line),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] mem_word(input int a);
    return (32'(a) * 32'h9E37_79B1) ^ 32'hC0DE_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // 0 = fast hit, 1 = slow hit, 2 = miss; updates the model
  function automatic int model(input logic [ADDR_W-1:0] a);
    int s = int'(a[5:2]);
    int t = int'(a[ADDR_W-1:6]);
    bit p = mpred[s];
    if (mval[s][p] && mtag[s][p] == t) return 0;
    if (mval[s][!p] && mtag[s][!p] == t) begin
      mpred[s] = !p;
      return 1;
    end
    mval[s][!p] = 1'b1;
    mtag[s][!p] = t;
    mpred[s]    = !p;
    return 2;
  endfunction

  // refill port: one cycle of ready, then beats 0,1,gap,2,3
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        logic [LINE_W-1:0] ln;
        ln = mem_req_line;
        mem_reqs++;
        chk(ln == exp_line, "R5 line", 32'(ln), 32'(exp_line));
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(!mem_req_valid, "R5 drop", 32'(mem_req_valid), 0);
        for (int b = 0; b < WORDS; b++) begin
          if (b == 2) begin
            mem_rsp_valid = 1'b0;
            @(negedge clk);
          end
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(int'(ln) * WORDS + b);
          @(negedge clk);
        end
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic access(input logic [ADDR_W-1:0] a, input string tag_s);
    int cls = model(a);
    int n = 0;
    int reqs0 = mem_reqs;
    bit ready_bad = 1'b0;
    exp_line = a[ADDR_W-1:2];
    @(negedge clk);
    chk(req_ready, "R8 idle ready", 32'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!rsp_valid && n < 40) begin
      if (req_ready) ready_bad = 1'b1;
      @(negedge clk);
      n++;
    end
    chk(rsp_valid, {tag_s, " R9 response"}, 32'(rsp_valid), 1);
    chk(rsp_data == mem_word(int'(a)), {tag_s, " R9 data"}, rsp_data, mem_word(int'(a)));
    if (cls == 0) begin
      chk(n == 1, {tag_s, " R2 latency"}, 32'(n), 1);
      chk(!rsp_slow, {tag_s, " R2 slow flag"}, 32'(rsp_slow), 0);
    end else if (cls == 1) begin
      chk(n == 2, {tag_s, " R3 latency"}, 32'(n), 2);
      chk(rsp_slow, {tag_s, " R3 slow flag"}, 32'(rsp_slow), 1);
      chk(mem_reqs == reqs0, {tag_s, " R3 no refill"}, 32'(mem_reqs - reqs0), 0);
      chk(!ready_bad && !req_ready, {tag_s, " R8 busy"}, 32'(ready_bad), 0);
    end else begin
      chk(n == 9, {tag_s, " R7 latency"}, 32'(n), 9);
      chk(rsp_slow, {tag_s, " R7 slow flag"}, 32'(rsp_slow), 1);
      chk(mem_reqs == reqs0 + 1, {tag_s, " R5 one refill"}, 32'(mem_reqs - reqs0), 1);
      chk(!ready_bad && !req_ready, {tag_s, " R8 busy"}, 32'(ready_bad), 0);
    end
    @(negedge clk);
    chk(!rsp_valid, {tag_s, " R3 single response"}, 32'(rsp_valid), 0);
  endtask

  task automatic expect_cls(input logic [ADDR_W-1:0] a, input int want, input string tag_s);
    int s = int'(a[5:2]);
    int t = int'(a[ADDR_W-1:6]);
    int got;
    bit p = mpred[s];
    if (mval[s][p] && mtag[s][p] == t) got = 0;
    else if (mval[s][!p] && mtag[s][!p] == t) got = 1;
    else got = 2;
    // guards the hand-built scenario against the written requirements
    chk(got == want, {tag_s, " scenario"}, 32'(got), 32'(want));
    access(a, tag_s);
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int t, input int s, input int o);
    return ADDR_W'((t << 6) | (s << 2) | o);
  endfunction

  task automatic b2b(input logic [ADDR_W-1:0] a0, input logic [ADDR_W-1:0] a1);
    int c0 = model(a0);
    int c1 = model(a1);
    chk(c0 == 0 && c1 == 0, "R8 b2b scenario", 32'(c0 + c1), 0);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a0;
    @(negedge clk);
    chk(rsp_valid && !rsp_slow, "R2 b2b first", 32'({rsp_valid, rsp_slow}), 32'b10);
    chk(rsp_data == mem_word(int'(a0)), "R9 b2b first data", rsp_data, mem_word(int'(a0)));
    chk(req_ready, "R8 ready on fast hit", 32'(req_ready), 1);
    req_addr = a1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && !rsp_slow, "R8 b2b second", 32'({rsp_valid, rsp_slow}), 32'b10);
    chk(rsp_data == mem_word(int'(a1)), "R9 b2b second data", rsp_data, mem_word(int'(a1)));
    @(negedge clk);
    chk(!rsp_valid, "R8 b2b end", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      mpred[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin
        mval[s][w] = 1'b0;
        mtag[s][w] = 0;
      end
    end
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(req_ready, "R1 reset ready", 32'(req_ready), 1);
    chk(!rsp_valid, "R1 reset rsp", 32'(rsp_valid), 0);
    chk(!mem_req_valid, "R1 reset refill", 32'(mem_req_valid), 0);

    // R1 R6 R7: cold miss fills way 1 of set 3
    expect_cls(mk(1, 3, 2), 2, "R1 cold");
    for (int o = 0; o < WORDS; o++) expect_cls(mk(1, 3, o), 0, "R2 line A");
    // R6: second tag fills way 0 and becomes predicted
    expect_cls(mk(2, 3, 1), 2, "R6 fill B");
    expect_cls(mk(2, 3, 3), 0, "R2 line B");
    // R3 then R4
    expect_cls(mk(1, 3, 0), 1, "R3 A other way");
    expect_cls(mk(1, 3, 1), 0, "R4 retrained");
    expect_cls(mk(2, 3, 0), 1, "R3 B other way");
    // R6: third tag evicts the non-predicted way (line A)
    expect_cls(mk(3, 3, 3), 2, "R6 fill C");
    expect_cls(mk(2, 3, 2), 1, "R6 B kept");
    expect_cls(mk(1, 3, 0), 2, "R6 A evicted");
    // back-to-back fast hits
    b2b(mk(1, 3, 1), mk(1, 3, 3));
    // sweep of other sets and tags
    for (int i = 0; i < 24; i++) access(mk((i * 5) % 7, (i * 3) % SETS, i % WORDS), "R9 sweep");
    for (int i = 0; i < 24; i++) access(mk((i * 5) % 7, (i * 3) % SETS, (i + 1) % WORDS), "R9 revisit");
    // top set and high tag boundary
    expect_cls(mk(1023, 15, 3), 2, "R5 high line");
    expect_cls(mk(1023, 15, 0), 0, "R7 high line hit");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule